// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Sequencer with Priority Chain

This block takes interrupt requests from outside the core and turns each one into a single vector for the trap logic. Devices that supply their own vector sit in a chain of slots ordered by priority. Slot 0 is the highest. Any slot that is requesting raises a shared request line. When interrupts are enabled, the sequencer answers with one acknowledge cycle. In that cycle it raises an acknowledge output and a read strobe together.

The acknowledge enters the chain at slot 0 and moves down combinationally within that cycle. The first requesting slot absorbs it and places its vector on the data path. At the end of the cycle the sequencer captures that vector. It then presents the vector on the next cycle with a one-cycle valid pulse.

Two dedicated request lines need no bus read, because each one maps to a fixed vector: octal 100 for the higher-priority line and octal 270 for the other. A third dedicated line ignores the enable and produces a one-cycle halt pulse. After every delivery the sequencer returns to idle. A higher-priority slot that raises its request later therefore wins the next acknowledge, ahead of lower slots that have waited longer. This is what allows nested service.

Top module: `vintr_ack_top`

## Requirements
- R1: While reset is held and right after it, irq_ack, rd_stb, dev_grant, chain_tail, vec_valid, vec_fixed and halt_enter are all 0.
- R2: While irq_en is 0, dev_req, fix_hi_req and fix_lo_req have no effect: no acknowledge cycle, no grant and no vec_valid follow.
- R3: When irq_en is 1 at a clock edge in idle, at least one dev_req bit is set and no dedicated line is pending, the next cycle has irq_ack and rd_stb both at 1. They stay at 1 for exactly one cycle.
- R4: During the acknowledge cycle, dev_grant is one-hot on the lowest-numbered requesting slot, because slot 0 has the highest priority. Slots after the winner see no grant.
- R5: The cycle after the acknowledge cycle, vec_valid is 1 for one cycle and vec_fixed is 0. vec_out then equals the winning slot's field dev_vec[i*VW +: VW].
- R6: If no slot is requesting during the acknowledge cycle, chain_tail is 1 and no vec_valid follows. The sequencer then goes back to idle.
- R7: fix_hi_req, when enabled, gives vec_valid with vec_fixed=1 and vec_out=0o100 (64) on the cycle after the edge that sees it. No acknowledge or read strobe is issued.
- R8: fix_lo_req gives vec_out=0o270 (184) in the same way. When both dedicated lines are pending, fix_hi_req wins.
- R9: A dedicated line that is pending at the same edge as a chain request wins over the chain.
- R10: halt_req gives a one-cycle halt_enter pulse on the cycle after the edge that sees it, whatever irq_en is. It has priority over every other request, and no vec_valid is produced for it.
- R11: After each delivery the sequencer accepts a new request. A slot with higher priority that raises its request after an earlier delivery is served before a lower slot that is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_en | input | 1 | Interrupt enable from the core |
| halt_req | input | 1 | Dedicated halt request line |
| fix_hi_req | input | 1 | Dedicated request, vector 0o100 |
| fix_lo_req | input | 1 | Dedicated request, vector 0o270 |
| dev_req | input | NSLOT | Per-slot vectored request; slot 0 has the highest priority |
| dev_vec | input | NSLOT*VW | Vector driven by each slot; slot i occupies bits [i*VW +: VW] |
| irq_ack | output | 1 | Interrupt acknowledge entering the chain |
| rd_stb | output | 1 | Read strobe during the acknowledge cycle |
| dev_grant | output | NSLOT | Grant seen by each slot during the acknowledge cycle |
| chain_tail | output | 1 | Acknowledge leaving the last slot unclaimed |
| vec_valid | output | 1 | One-cycle pulse marking vec_out valid |
| vec_out | output | VW | Captured vector |
| vec_fixed | output | 1 | The vector came from a dedicated line |
| halt_enter | output | 1 | One-cycle halt pulse |

## Verification
The assertions assume that a slot changes its request only away from the clock edge. They also assume that the acknowledge cycle sees a stable request pattern, and that irq_en is a defined level at each edge where the sequencer is idle. The bench changes every input on the falling edge only. It holds the requests through the acknowledge cycle, and releases them once the delivery is visible. The exception is the one directed case that deliberately withdraws a request during the acknowledge cycle to exercise the unclaimed path.

// File: rtl/vintr_pkg.sv
`timescale 1ns/1ps
package vintr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

  typedef enum logic [2:0] {
    SRC_NONE   = 3'd0,
    SRC_HALT   = 3'd1,
    SRC_FIX_HI = 3'd2,
    SRC_FIX_LO = 3'd3,
    SRC_CHAIN  = 3'd4
  } req_src_e;

  localparam int unsigned FIXED_VEC_HI = 'o100;
  localparam int unsigned FIXED_VEC_LO = 'o270;

  // Priority order among request classes: halt, high fixed, low fixed, chain
  function automatic req_src_e pick_source(input logic en, input logic halt,
                                           input logic fhi, input logic flo,
                                           input logic shared);
    if (halt)               return SRC_HALT;
    else if (en && fhi)     return SRC_FIX_HI;
    else if (en && flo)     return SRC_FIX_LO;
    else if (en && shared)  return SRC_CHAIN;
    else                    return SRC_NONE;
  endfunction

  function automatic int unsigned fixed_vector(input req_src_e src);
    return (src == SRC_FIX_HI) ? FIXED_VEC_HI : FIXED_VEC_LO;
  endfunction

endpackage

// File: rtl/vintr_chain_slot.sv
`timescale 1ns/1ps
module vintr_chain_slot (
  input  logic ack_in,
  input  logic req,
  output logic grant,
  output logic ack_pass
);
  // A requesting slot absorbs the acknowledge; an idle one forwards it
  assign grant    = ack_in & req;
  assign ack_pass = ack_in & ~req;
endmodule

// File: rtl/vintr_chain.sv
`timescale 1ns/1ps
module vintr_chain #(
  parameter int unsigned NSLOT = 4,
  parameter int unsigned VW    = 16
) (
  input  logic                dev_ack,
  input  logic [NSLOT-1:0]    dev_req,
  input  logic [NSLOT*VW-1:0] dev_vec,
  output logic                shared_req,
  output logic [NSLOT-1:0]    grant,
  output logic                hit,
  output logic                tail,
  output logic [VW-1:0]       sel_vec
);
  logic [NSLOT:0] ack_link;
  logic [VW-1:0]  masked [NSLOT];

  assign ack_link[0] = dev_ack;
  assign shared_req  = |dev_req;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    vintr_chain_slot u_slot (
      .ack_in   (ack_link[i]),
      .req      (dev_req[i]),
      .grant    (grant[i]),
      .ack_pass (ack_link[i+1])
    );
    assign masked[i] = grant[i] ? dev_vec[i*VW +: VW] : '0;
  end

  always_comb begin
    sel_vec = '0;
    for (int i = 0; i < NSLOT; i++) sel_vec = sel_vec | masked[i];
  end

  assign hit  = |grant;
  assign tail = ack_link[NSLOT];
endmodule

// File: rtl/vintr_seq.sv
`timescale 1ns/1ps
module vintr_seq
  import vintr_pkg::*;
#(
  parameter int unsigned VW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_en,
  input  logic          halt_req,
  input  logic          fix_hi_req,
  input  logic          fix_lo_req,
  input  logic          shared_req,
  input  logic          chain_hit,
  input  logic          chain_tail,
  input  logic [VW-1:0] chain_vec,
  output logic          irq_ack,
  output logic          rd_stb,
  output logic          vec_valid,
  output logic [VW-1:0] vec_out,
  output logic          vec_fixed,
  output logic          halt_enter
);
  seq_state_e    state_q;
  req_src_e      src;
  logic          valid_q, fixed_q, halt_q;
  logic [VW-1:0] vec_q;

  assign src = pick_source(irq_en, halt_req, fix_hi_req, fix_lo_req, shared_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      valid_q <= 1'b0;
      fixed_q <= 1'b0;
      halt_q  <= 1'b0;
      vec_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      fixed_q <= 1'b0;
      halt_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          case (src)
            SRC_HALT: begin
              halt_q  <= 1'b1;
              state_q <= ST_DONE;
            end
            SRC_FIX_HI, SRC_FIX_LO: begin
              valid_q <= 1'b1;
              fixed_q <= 1'b1;
              vec_q   <= VW'(fixed_vector(src));
              state_q <= ST_DONE;
            end
            SRC_CHAIN: state_q <= ST_ACK;
            default:   state_q <= ST_IDLE;
          endcase
        end
        ST_ACK: begin
          if (chain_hit) begin
            valid_q <= 1'b1;
            vec_q   <= chain_vec;
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign irq_ack    = (state_q == ST_ACK);
  assign rd_stb     = (state_q == ST_ACK);
  assign vec_valid  = valid_q;
  assign vec_out    = vec_q;
  assign vec_fixed  = fixed_q;
  assign halt_enter = halt_q;

  AST_ACK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> $past(irq_en)); // R2
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack); // R3
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid); // R5
  AST_CHAIN_VALID_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_fixed) |-> $past(irq_ack)); // R5
  AST_TAIL_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    chain_tail |=> !vec_valid); // R6
  AST_FIXED_SKIPS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_fixed) |-> !$past(irq_ack)); // R7
  AST_HALT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_enter |=> !halt_enter); // R10
  AST_HALT_NO_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    halt_enter |-> !vec_valid); // R10
endmodule

// File: rtl/vintr_ack_top.sv
`timescale 1ns/1ps
module vintr_ack_top #(
  parameter int unsigned NSLOT = 4,
  parameter int unsigned VW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                irq_en,
  input  logic                halt_req,
  input  logic                fix_hi_req,
  input  logic                fix_lo_req,
  input  logic [NSLOT-1:0]    dev_req,
  input  logic [NSLOT*VW-1:0] dev_vec,
  output logic                irq_ack,
  output logic                rd_stb,
  output logic [NSLOT-1:0]    dev_grant,
  output logic                chain_tail,
  output logic                vec_valid,
  output logic [VW-1:0]       vec_out,
  output logic                vec_fixed,
  output logic                halt_enter
);
  logic          shared_req;
  logic          chain_hit;
  logic [VW-1:0] chain_vec;

  vintr_chain #(.NSLOT(NSLOT), .VW(VW)) u_chain (
    .dev_ack    (irq_ack),
    .dev_req    (dev_req),
    .dev_vec    (dev_vec),
    .shared_req (shared_req),
    .grant      (dev_grant),
    .hit        (chain_hit),
    .tail       (chain_tail),
    .sel_vec    (chain_vec)
  );

  vintr_seq #(.VW(VW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_en     (irq_en),
    .halt_req   (halt_req),
    .fix_hi_req (fix_hi_req),
    .fix_lo_req (fix_lo_req),
    .shared_req (shared_req),
    .chain_hit  (chain_hit),
    .chain_tail (chain_tail),
    .chain_vec  (chain_vec),
    .irq_ack    (irq_ack),
    .rd_stb     (rd_stb),
    .vec_valid  (vec_valid),
    .vec_out    (vec_out),
    .vec_fixed  (vec_fixed),
    .halt_enter (halt_enter)
  );

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_grant)); // R4
  AST_GRANT_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_grant) |-> rd_stb); // R4
endmodule

// File: tb/vintr_ack_top_bench.sv
`timescale 1ns/1ps
module vintr_ack_top_bench;
  localparam int NSLOT = 4;
  localparam int VW    = 16;
  localparam logic [1:0] P_NONE = 2'd0, P_CHAIN = 2'd1, P_FIX = 2'd2, P_HALT = 2'd3;

  typedef struct packed {
    logic       en;
    logic       hlt;
    logic       fhi;
    logic       flo;
    logic [3:0] req;
    logic [1:0] path;
    logic [3:0] gnt;
    logic [15:0] vec;
  } case_t;

  localparam int NCASE = 13;
  localparam case_t TBL [NCASE] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 4'b0001, P_NONE,  4'b0000, 16'h0000},
    '{1'b0, 1'b0, 1'b1, 1'b1, 4'b0000, P_NONE,  4'b0000, 16'h0000},
    '{1'b0, 1'b1, 1'b0, 1'b0, 4'b0010, P_HALT,  4'b0000, 16'h0000},
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'b0100, P_CHAIN, 4'b0100, 16'h0108},
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'b1010, P_CHAIN, 4'b0010, 16'h0104},
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'b1111, P_CHAIN, 4'b0001, 16'h0100},
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'b1000, P_CHAIN, 4'b1000, 16'h010C},
    '{1'b1, 1'b0, 1'b1, 1'b0, 4'b0000, P_FIX,   4'b0000, 16'h0040},
    '{1'b1, 1'b0, 1'b0, 1'b1, 4'b0000, P_FIX,   4'b0000, 16'h00B8},
    '{1'b1, 1'b0, 1'b1, 1'b1, 4'b0000, P_FIX,   4'b0000, 16'h0040},
    '{1'b1, 1'b0, 1'b0, 1'b1, 4'b0001, P_FIX,   4'b0000, 16'h00B8},
    '{1'b1, 1'b1, 1'b1, 1'b0, 4'b0001, P_HALT,  4'b0000, 16'h0000},
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, P_NONE,  4'b0000, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_en = 1'b0, halt_req = 1'b0, fix_hi_req = 1'b0, fix_lo_req = 1'b0;
  logic [NSLOT-1:0] dev_req = '0;
  logic [NSLOT*VW-1:0] dev_vec;
  logic irq_ack, rd_stb, chain_tail, vec_valid, vec_fixed, halt_enter;
  logic [NSLOT-1:0] dev_grant;
  logic [VW-1:0] vec_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // Slot i returns 0x100 + 4*i
  function automatic logic [VW-1:0] slot_vec(input int i);
    return VW'(16'h0100 + 4 * i);
  endfunction

  always_comb
    for (int i = 0; i < NSLOT; i++) dev_vec[i*VW +: VW] = slot_vec(i);

  vintr_ack_top #(.NSLOT(NSLOT), .VW(VW)) u_vintr_ack_top (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .halt_req(halt_req),
    .fix_hi_req(fix_hi_req), .fix_lo_req(fix_lo_req), .dev_req(dev_req),
    .dev_vec(dev_vec), .irq_ack(irq_ack), .rd_stb(rd_stb), .dev_grant(dev_grant),
    .chain_tail(chain_tail), .vec_valid(vec_valid), .vec_out(vec_out),
    .vec_fixed(vec_fixed), .halt_enter(halt_enter)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic eq(input string tag, input string what,
                    input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, tag, what, act, exp);
  endtask

  function automatic string tag_of(input int i);
    case (i)
      0, 1, 12: return "R2";
      2, 11:    return "R10";
      3, 4, 5, 6: return "R4";
      7:        return "R7";
      8, 9:     return "R8";
      10:       return "R9";
      default:  return "R2";
    endcase
  endfunction

  task automatic clear_inputs();
    halt_req = 1'b0; fix_hi_req = 1'b0; fix_lo_req = 1'b0; dev_req = '0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); #0.5;
  endtask

  task automatic run_case(input int idx);
    case_t c;
    string t;
    c = TBL[idx];
    t = tag_of(idx);
    irq_en = c.en; halt_req = c.hlt; fix_hi_req = c.fhi; fix_lo_req = c.flo;
    dev_req = c.req;
    step();
    // First cycle after the deciding edge
    eq((c.path == P_CHAIN) ? "R3" : t, "ack", irq_ack, c.path == P_CHAIN);
    eq((c.path == P_CHAIN) ? "R3" : t, "rd_stb", rd_stb, c.path == P_CHAIN);
    eq(t, "grant", dev_grant, c.gnt);
    eq(t, "tail", chain_tail, 1'b0);
    eq(t, "valid1", vec_valid, c.path == P_FIX);
    eq(t, "fixed1", vec_fixed, c.path == P_FIX);
    eq(t, "halt1", halt_enter, c.path == P_HALT);
    if (c.path == P_FIX) eq(t, "vec1", vec_out, c.vec);
    step();
    // Second cycle: chain delivery, all else quiet
    eq((c.path == P_CHAIN) ? "R3" : t, "ack2", irq_ack, 1'b0);
    eq((c.path == P_CHAIN) ? "R5" : t, "valid2", vec_valid, c.path == P_CHAIN);
    eq((c.path == P_CHAIN) ? "R5" : t, "fixed2", vec_fixed, 1'b0);
    eq(t, "halt2", halt_enter, 1'b0);
    if (c.path == P_CHAIN) eq("R5", "vec2", vec_out, c.vec);
    clear_inputs();
    step();
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: outputs quiet under reset and right after release
    repeat (3) @(negedge clk);
    eq("R1", "ack_rst", irq_ack, 1'b0);
    eq("R1", "valid_rst", vec_valid, 1'b0);
    eq("R1", "halt_rst", halt_enter, 1'b0);
    eq("R1", "grant_rst", dev_grant, '0);
    rst_n = 1'b1;
    step();
    eq("R1", "ack_post", {irq_ack, rd_stb, chain_tail, vec_valid, vec_fixed, halt_enter}, 6'b0);

    for (int i = 0; i < NCASE; i++) run_case(i);

    // R6: request withdrawn during the acknowledge cycle
    irq_en = 1'b1; dev_req = 4'b0001;
    @(posedge clk); @(negedge clk);
    dev_req = '0;
    #0.5;
    eq("R6", "ack", irq_ack, 1'b1);
    eq("R6", "grant", dev_grant, 4'b0000);
    eq("R6", "tail", chain_tail, 1'b1);
    step();
    eq("R6", "valid", vec_valid, 1'b0);
    step();
    eq("R6", "idle", irq_ack, 1'b0);

    // R11: later higher-priority request overtakes waiting lower one
    dev_req = 4'b1100;
    step();
    eq("R11", "grant_a", dev_grant, 4'b0100);
    step();
    eq("R11", "vec_a", vec_out, slot_vec(2));
    eq("R11", "valid_a", vec_valid, 1'b1);
    dev_req = 4'b1001;
    step();
    step();
    eq("R11", "grant_b", dev_grant, 4'b0001);
    step();
    eq("R11", "vec_b", vec_out, slot_vec(0));
    dev_req = 4'b1000;
    step();
    step();
    eq("R11", "grant_c", dev_grant, 4'b1000);
    step();
    eq("R11", "vec_c", vec_out, slot_vec(3));
    eq("R11", "valid_c", vec_valid, 1'b1);
    clear_inputs();
    step();
    step();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule